// File: doc/BRIEF.md
# Page Write Buffer and Commit Unit

This block sits behind a two-wire bus controller in a serial byte-addressed storage device. During a write transaction the controller hands it a starting address and then one strobe per received data byte. The block collects those bytes into a one-page staging buffer of 64 bytes. Each accepted byte advances only the column part of the address, so a long burst wraps back to the start of the same page and overwrites what it staged earlier.

When the controller reports the stop event, the block starts one timed write cycle. For a parameterized number of clock cycles it holds `busy` high. During the first 64 of those cycles it walks the page column by column and writes every staged byte into a synchronous byte memory through a simple write port. Columns that were not written in the transaction keep their old contents. While the write-protect input is high, no byte is written into the upper eighth of the array.

The block also keeps the current-address counter that reads use. After a write transaction this counter points one past the last staged byte, wrapped within the page. Each read-advance strobe steps the full address, crosses page boundaries and wraps from the last address of the array to zero.

Top module: `page_commit_unit`

## Requirements
- R1: An idle `byte_vld` stores `byte_in` at the column given by the low 6 bits of `cur_addr` and increments only those 6 bits. Column 63 is followed by column 0 of the same page, and the upper address bits stay unchanged.
- R2: When a column is staged more than once in one transaction, only the value staged last is committed.
- R3: A `stop_evt` while idle with at least one staged byte makes `busy` high from the next cycle for exactly WCYC cycles. After that `busy` is low.
- R4: During a write cycle, `mem_we` pulses once for each staged column, in ascending column order, within the first 64 busy cycles. Each write uses `mem_addr` = {page bits of `cur_addr`, column} and `mem_wdata` = the staged byte. Unstaged columns get no write.
- R5: A `stop_evt` with no staged byte leaves `busy` low and produces no memory write.
- R6: While `wp_in` is 1, no write is issued to an address whose top three bits are 111 (the upper eighth of the array). Lower addresses, and all addresses while `wp_in` is 0, are written normally.
- R7: An idle `rd_adv` (with no `addr_load` or `byte_vld` in the same cycle) increments the full `cur_addr` by one, across page boundaries, wrapping from all-ones to zero.
- R8: An idle `addr_load` sets `cur_addr` to `addr_in` and discards all staged bytes. It takes priority over `byte_vld`, which takes priority over `rd_adv`.
- R9: While `busy` is high, `addr_load`, `byte_vld`, `rd_adv` and `stop_evt` have no effect. Staged bytes are discarded when the write cycle ends.
- R10: After reset `busy` and `mem_we` are low, no bytes are staged, and `cur_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | Load start address and begin a new transaction |
| addr_in | input | ADDR_W | Address to load |
| byte_vld | input | 1 | One received data byte is present |
| byte_in | input | 8 | Received data byte |
| stop_evt | input | 1 | Stop event ending the transaction |
| wp_in | input | 1 | Write protect for the upper eighth |
| rd_adv | input | 1 | Step the address after a read byte |
| busy | output | 1 | Timed write cycle in progress |
| cur_addr | output | ADDR_W | Current address |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write data |

## Verification
The bench builds the block with ADDR_W = 9 and WCYC = 100. The 9-bit address gives eight pages of 64 bytes, so the protected upper eighth is exactly the last page and the wrap from the last address to zero is reached in a few strobes. A write cycle of 100 clocks holds the full 64-column commit sweep plus idle tail, so the busy length, the order of the writes and the inputs that must be ignored while busy can all be checked in a short run.

// File: rtl/pcu_pkg.sv
// Package: shared constants and helpers for the page commit unit.
// Assumes the protected region is selected by the three top address bits.
package pcu_pkg;
    localparam int BYTE_W = 8;

    // True when the three most significant address bits select the top eighth.
    function automatic logic in_top_eighth(input logic [2:0] top3);
        return &top3;
    endfunction
endpackage

// File: rtl/pcu_buffer.sv
// Module: one-page staging buffer with a per-column valid mask.
// Assumes at most one write per cycle; clear wins over write.
module pcu_buffer #(
    parameter int PAGE_W = 6,
    localparam int PAGE_SZ = 1 << PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_col,
    input  logic [7:0]        wr_data,
    input  logic              clr,
    input  logic [PAGE_W-1:0] rd_col,
    output logic [7:0]        rd_data,
    output logic              rd_vld,
    output logic              any_vld
);
    logic [7:0]         lane [PAGE_SZ];
    logic [PAGE_SZ-1:0] vmask;

    for (genvar c = 0; c < PAGE_SZ; c++) begin : g_lane
        // Purpose: hold the byte and the valid bit of one column.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                vmask[c] <= 1'b0;
            end else if (wr_en && wr_col == PAGE_W'(c)) begin
                vmask[c] <= 1'b1;
                lane[c]  <= wr_data;
            end
        end
    end

    // Purpose: present the column being committed.
    always_comb begin
        rd_data = lane[rd_col];
        rd_vld  = vmask[rd_col];
        any_vld = |vmask;
    end
endmodule

// File: rtl/pcu_addr.sv
// Module: current-address counter with page-local and full-width stepping.
// Assumes the caller has already resolved priority between the requests.
module pcu_addr #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_col,
    input  logic              step_all,
    output logic [ADDR_W-1:0] cur
);
    // Purpose: load, step within the page, or step the whole address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load) begin
            cur <= load_val;
        end else if (step_col) begin
            cur[PAGE_W-1:0] <= cur[PAGE_W-1:0] + 1'b1;
        end else if (step_all) begin
            cur <= cur + 1'b1;
        end
    end
endmodule

// File: rtl/pcu_timer.sv
// Module: write-cycle timer; busy for exactly WCYC cycles after a start.
// Assumes start is only raised while not busy.
module pcu_timer #(
    parameter int WCYC = 2500000,
    localparam int TMR_W = $clog2(WCYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [TMR_W-1:0] tmr,
    output logic             done
);
    assign done = busy && (tmr == TMR_W'(WCYC - 1));

    // Purpose: run the busy interval and count its cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            tmr  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            tmr  <= '0;
        end else if (busy) begin
            tmr <= tmr + 1'b1;
            if (done) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/page_commit_unit.sv
// Module: page write buffer and commit unit (top).
// Stages write bytes into one page and commits them in a timed write cycle
// on stop; keeps the current address for reads. Assumes WCYC >= 64 so the
// column sweep fits inside the busy interval, and ADDR_W >= PAGE_W + 3.
module page_commit_unit #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6,
    parameter int WCYC   = 2500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic              stop_evt,
    input  logic              wp_in,
    input  logic              rd_adv,
    output logic              busy,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    import pcu_pkg::*;

    localparam int PAGE_SZ = 1 << PAGE_W;
    localparam int TMR_W   = $clog2(WCYC + 1);

    logic              idle, do_load, do_byte, do_step, do_start;
    logic              any_vld, col_vld, done, in_sweep;
    logic [TMR_W-1:0]  tmr;
    logic [7:0]        col_data;
    logic [PAGE_W-1:0] sweep_col;

    // Purpose: resolve request priority; everything is ignored while busy.
    always_comb begin
        idle     = !busy;
        do_load  = idle && addr_load;
        do_byte  = idle && !addr_load && byte_vld;
        do_step  = idle && !addr_load && !byte_vld && rd_adv;
        do_start = idle && !addr_load && !byte_vld && stop_evt && any_vld;
    end

    pcu_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
        .clk(clk), .rst_n(rst_n),
        .load(do_load), .load_val(addr_in),
        .step_col(do_byte), .step_all(do_step),
        .cur(cur_addr)
    );

    pcu_buffer #(.PAGE_W(PAGE_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(do_byte), .wr_col(cur_addr[PAGE_W-1:0]), .wr_data(byte_in),
        .clr(do_load || done),
        .rd_col(sweep_col), .rd_data(col_data), .rd_vld(col_vld),
        .any_vld(any_vld)
    );

    pcu_timer #(.WCYC(WCYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(do_start),
        .busy(busy), .tmr(tmr), .done(done)
    );

    // Purpose: drive the memory write port during the column sweep.
    always_comb begin
        sweep_col = tmr[PAGE_W-1:0];
        in_sweep  = busy && (32'(tmr) < PAGE_SZ);
        mem_addr  = {cur_addr[ADDR_W-1:PAGE_W], sweep_col};
        mem_wdata = col_data;
        mem_we    = in_sweep && col_vld &&
                    !(wp_in && in_top_eighth(mem_addr[ADDR_W-1 -: 3]));
    end
endmodule

// File: rtl/pcu_checker.sv
// Module: property checker for the page commit unit, bound to the top.
// Assumes it observes only the top-level ports.
module pcu_checker #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6,
    parameter int WCYC   = 2500000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_load,
    input logic              byte_vld,
    input logic              stop_evt,
    input logic              wp_in,
    input logic              rd_adv,
    input logic              busy,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    int unsigned bcnt;

    // Purpose: count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) bcnt <= 0;
        else                 bcnt <= bcnt + 1;
    end

    p_we_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);
    p_we_same_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[ADDR_W-1:PAGE_W] == cur_addr[ADDR_W-1:PAGE_W]);
    p_wp_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !(wp_in && (&mem_addr[ADDR_W-1 -: 3])));
    p_busy_from_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));
    p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> bcnt == WCYC);
    p_busy_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> bcnt < WCYC);
    p_addr_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cur_addr));
    p_read_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd_adv && !addr_load && !byte_vld)
        |=> cur_addr == ADDR_W'($past(cur_addr) + 1'b1));
endmodule

bind page_commit_unit pcu_checker #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WCYC(WCYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .byte_vld(byte_vld),
    .stop_evt(stop_evt), .wp_in(wp_in), .rd_adv(rd_adv), .busy(busy),
    .cur_addr(cur_addr), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/sim_page_commit_unit.sv
// Scoreboard bench: stimulus tasks push expected memory writes, a monitor
// pops and compares them as the design issues them.
module sim_page_commit_unit;
    localparam int AW    = 9;
    localparam int WC    = 100;
    localparam int PSZ   = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_load = 0, byte_vld = 0, stop_evt = 0, wp_in = 0, rd_adv = 0;
    logic [AW-1:0] addr_in = '0;
    logic [7:0]    byte_in = '0;
    logic          busy, mem_we;
    logic [AW-1:0] cur_addr, mem_addr;
    logic [7:0]    mem_wdata;

    int n_chk = 0, n_bad = 0;
    logic [AW+7:0] expq[$];
    logic [7:0]    m_buf [PSZ];
    logic          m_vld [PSZ];
    logic [AW-1:0] m_addr;

    always #2 clk = ~clk;

    page_commit_unit #(.ADDR_W(AW), .PAGE_W(6), .WCYC(WC)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_vld(byte_vld), .byte_in(byte_in), .stop_evt(stop_evt),
        .wp_in(wp_in), .rd_adv(rd_adv), .busy(busy), .cur_addr(cur_addr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare every memory write with the head of the queue (R4, R6).
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (expq.size() == 0) check("R4 unexpected write", {mem_addr, mem_wdata}, 0);
            else check("R4 write", {mem_addr, mem_wdata}, expq.pop_front());
        end
    end

    task automatic pulse_load(input logic [AW-1:0] a);
        @(posedge clk); #1 addr_load = 1; addr_in = a;
        @(posedge clk); #1 addr_load = 0;
        if (!busy) begin
            m_addr = a;
            for (int c = 0; c < PSZ; c++) m_vld[c] = 0;
        end
    endtask

    task automatic put_byte(input logic [7:0] d);
        @(posedge clk); #1 byte_vld = 1; byte_in = d;
        @(posedge clk); #1 byte_vld = 0;
        if (!busy) begin
            m_buf[m_addr[5:0]] = d;
            m_vld[m_addr[5:0]] = 1;
            m_addr[5:0] = m_addr[5:0] + 1'b1;
        end
    endtask

    task automatic step_read();
        @(posedge clk); #1 rd_adv = 1;
        @(posedge clk); #1 rd_adv = 0;
        m_addr = m_addr + 1'b1;
    endtask

    // Driver: issue stop and push the writes the requirements predict.
    task automatic stop_and_commit(input bit expect_busy);
        logic [AW-1:0] a;
        int cnt;
        for (int c = 0; c < PSZ; c++) begin
            a = {m_addr[AW-1:6], 6'(c)};
            if (m_vld[c] && !(wp_in && (&a[AW-1 -: 3]))) expq.push_back({a, m_buf[c]});
        end
        @(posedge clk); #1 stop_evt = 1;
        @(posedge clk); #1 stop_evt = 0;
        cnt = 0;
        @(negedge clk);
        while (busy && cnt < WC + 10) begin cnt++; @(negedge clk); end
        // R3 busy length, R5 no busy without data
        check(expect_busy ? "R3 busy cycles" : "R5 busy stays low", cnt, expect_busy ? WC : 0);
        check("R4 all writes seen", expq.size(), 0);
        expq.delete();
        for (int c = 0; c < PSZ; c++) m_vld[c] = 0;
    endtask

    initial begin
        #400000;
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < PSZ; c++) begin m_vld[c] = 0; m_buf[c] = 0; end
        m_addr = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check("R10 busy", busy, 0);
        check("R10 mem_we", mem_we, 0);
        check("R10 cur_addr", cur_addr, 0);

        // R1/R4 single byte
        pulse_load(9'h010); put_byte(8'hA5);
        @(negedge clk); check("R1 addr after byte", cur_addr, 9'h011);
        stop_and_commit(1);
        check("R1 addr after commit", cur_addr, 9'h011);

        // R1 page wrap: columns 62,63,0,1
        pulse_load(9'h03E);
        for (int i = 0; i < 4; i++) put_byte(8'(8'h30 + i));
        @(negedge clk); check("R1 column wrap", cur_addr, 9'h002);
        stop_and_commit(1);

        // R2 overwrite: 66 bytes from column 63 of page 1
        pulse_load(9'h07F);
        for (int i = 0; i < 66; i++) put_byte(8'(i + 1));
        @(negedge clk); check("R2 addr after 66", cur_addr, 9'h041);
        stop_and_commit(1);

        // R5 stop with nothing staged
        pulse_load(9'h0C5);
        stop_and_commit(0);
        check("R5 addr kept", cur_addr, 9'h0C5);

        // R6 protection on last page, then lower page, then WP low
        wp_in = 1;
        pulse_load(9'h1C4); put_byte(8'h11); put_byte(8'h22);
        stop_and_commit(1);
        pulse_load(9'h184); put_byte(8'h33);
        stop_and_commit(1);
        wp_in = 0;
        pulse_load(9'h1F0); put_byte(8'h44);
        stop_and_commit(1);

        // R7 read stepping across a page and across the top
        pulse_load(9'h03F); step_read();
        @(negedge clk); check("R7 page cross", cur_addr, 9'h040);
        pulse_load(9'h1FF); step_read();
        @(negedge clk); check("R7 wrap to zero", cur_addr, 9'h000);

        // R8 load beats byte in the same cycle, and discards staged bytes
        pulse_load(9'h020); put_byte(8'h55);
        @(posedge clk); #1 addr_load = 1; addr_in = 9'h0A0; byte_vld = 1; byte_in = 8'h66;
        @(posedge clk); #1 addr_load = 0; byte_vld = 0;
        m_addr = 9'h0A0; for (int c = 0; c < PSZ; c++) m_vld[c] = 0;
        @(negedge clk); check("R8 load priority", cur_addr, 9'h0A0);
        stop_and_commit(0);

        // R9 inputs ignored while busy
        pulse_load(9'h050); put_byte(8'h77);
        for (int c = 0; c < PSZ; c++)
            if (m_vld[c]) expq.push_back({{m_addr[AW-1:6], 6'(c)}, m_buf[c]});
        @(posedge clk); #1 stop_evt = 1;
        @(posedge clk); #1 stop_evt = 0;
        pulse_load(9'h123); put_byte(8'h88); step_read();
        @(posedge clk); #1 stop_evt = 1;
        @(posedge clk); #1 stop_evt = 0;
        @(negedge clk); check("R9 addr frozen", cur_addr, 9'h051);
        while (busy) @(negedge clk);
        check("R9 writes complete", expq.size(), 0);
        check("R9 addr after busy", cur_addr, 9'h051);
        for (int c = 0; c < PSZ; c++) m_vld[c] = 0;
        m_addr = 9'h051;
        stop_and_commit(0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule